// File: doc/BRIEF.md
# Push-Button Vending Menu Controller

This block is the control core of a small vending machine whose front panel is a text display and four push-buttons. It receives one-cycle button pulses that have already been debounced: go home, step, pick item and insert coin. It drives a screen code for the display driver, the index of the item currently chosen, the credit collected so far, and a one-cycle vend strobe for the dispensing mechanism.

All navigation runs on the single step button, and what a step does depends on the screen being shown. From the home screen, where the item list scrolls, step moves to item selection and then to the deposit screen. On the deposit screen, step compares the credit with the price of the chosen item. If the credit is too low, the controller shows a short-of-funds screen, and a further step returns to the deposit screen with the credit kept. If the credit covers the price, the controller shows the vending screen and pulses the vend strobe. The home button, or a step on the vending screen, starts a new session with the credit and the item index cleared.

Top module: `vend_menu_ctrl`

## Requirements
- R1: After rst_n is released, screen_o is 0 (home), item_o is 0, credit_o is 0 and vend_o is 0. Screen codes: 0 home, 1 select, 2 deposit, 3 short of funds, 4 vending.
- R2: A btn_home pulse on any screen puts screen_o at 0 with credit_o and item_o at 0 in the following cycle. It takes priority over every other button pressed in the same cycle.
- R3: A btn_step pulse moves screen 0 to screen 1, and screen 1 to screen 2, in the following cycle.
- R4: On screen 1, each btn_pick pulse increments item_o by one, and item 3 wraps back to item 0.
- R5: On screen 2, each btn_coin pulse adds 25 to credit_o, and the result saturates at 255.
- R6: Item prices are 50 + 25 × item index (50, 75, 100, 125). A btn_step pulse on screen 2 with credit_o below the price of item_o moves to screen 3.
- R7: A btn_step pulse on screen 3 returns to screen 2, and credit_o is unchanged.
- R8: A btn_step pulse on screen 2 with credit_o at or above the price moves to screen 4. vend_o is high for exactly the first cycle in which screen 4 is shown.
- R9: A btn_step pulse on screen 4 returns to screen 0 with credit_o and item_o cleared to 0.
- R10: btn_pick has no effect outside screen 1, and btn_coin has no effect outside screen 2. Both are also ignored in any cycle in which btn_step or btn_home is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| btn_home | input | 1 | Go-home pulse |
| btn_step | input | 1 | Step pulse |
| btn_pick | input | 1 | Next-item pulse |
| btn_coin | input | 1 | Coin-inserted pulse |
| screen_o | output | 3 | Screen code for the display |
| item_o | output | 2 | Chosen item index |
| credit_o | output | 8 | Credit collected |
| vend_o | output | 1 | One-cycle dispense strobe |

## Verification
The step branch on the deposit screen is driven with credit below the price, exactly equal to it, and above it. This separates a strict comparison from an inclusive one, and a wrong price lookup from a right one. Pick sequences run past the last item to expose a missing wrap, and coin runs go past 255 to tell saturation apart from wraparound. Pick and coin pulses are applied on the wrong screens and together with step or home, and the item and credit outputs are then read back at the ports. This shows whether the screen and priority gating is present.

// File: rtl/vmc_pkg.sv
package vmc_pkg;
  typedef enum logic [2:0] {
    SCR_HOME    = 3'd0,
    SCR_SELECT  = 3'd1,
    SCR_DEPOSIT = 3'd2,
    SCR_SHORT   = 3'd3,
    SCR_VEND    = 3'd4
  } screen_e;

  // price of an item: base plus a fixed step per index
  function automatic int price_of(int idx, int base, int step);
    return base + step * idx;
  endfunction

  // add with saturation at maxv
  function automatic int sat_add(int cur, int inc, int maxv);
    int s;
    s = cur + inc;
    return (s > maxv) ? maxv : s;
  endfunction
endpackage

// File: rtl/vmc_screen_fsm.sv
module vmc_screen_fsm
  import vmc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    home_ev,
  input  logic    step_ev,
  input  logic    credit_ok,
  output screen_e screen,
  output logic    go_home,
  output logic    enter_vend,
  output logic    vend_q
);
  screen_e nxt;

  always_comb begin
    nxt = screen;
    if (home_ev) nxt = SCR_HOME;
    else if (step_ev) begin
      case (screen)
        SCR_HOME:    nxt = SCR_SELECT;
        SCR_SELECT:  nxt = SCR_DEPOSIT;
        SCR_DEPOSIT: nxt = credit_ok ? SCR_VEND : SCR_SHORT;
        SCR_SHORT:   nxt = SCR_DEPOSIT;
        SCR_VEND:    nxt = SCR_HOME;
        default:     nxt = SCR_HOME;
      endcase
    end
  end

  assign go_home    = home_ev || (step_ev && screen == SCR_VEND);
  assign enter_vend = !home_ev && step_ev && screen == SCR_DEPOSIT && credit_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      screen <= SCR_HOME;
      vend_q <= 1'b0;
    end else begin
      screen <= nxt;
      vend_q <= enter_vend;
    end
  end
endmodule

// File: rtl/vmc_item_sel.sv
module vmc_item_sel #(
  parameter int NUM_ITEMS = 4,
  localparam int ITEM_W = $clog2(NUM_ITEMS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              adv,
  output logic [ITEM_W-1:0] idx
);
  localparam logic [ITEM_W-1:0] LAST = ITEM_W'(NUM_ITEMS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx <= '0;
    else if (clear)  idx <= '0;
    else if (adv)    idx <= (idx == LAST) ? '0 : idx + 1'b1;
  end
endmodule

// File: rtl/vmc_credit.sv
module vmc_credit
  import vmc_pkg::*;
#(
  parameter int CREDIT_W  = 8,
  parameter int COIN_STEP = 25
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                add,
  output logic [CREDIT_W-1:0] credit
);
  localparam int CMAX = (1 << CREDIT_W) - 1;

  logic [CREDIT_W-1:0] bumped;
  assign bumped = CREDIT_W'(sat_add(int'(credit), COIN_STEP, CMAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     credit <= '0;
    else if (clear) credit <= '0;
    else if (add)   credit <= bumped;
  end
endmodule

// File: rtl/vend_menu_ctrl.sv
module vend_menu_ctrl
  import vmc_pkg::*;
#(
  parameter int NUM_ITEMS  = 4,
  parameter int CREDIT_W   = 8,
  parameter int COIN_STEP  = 25,
  parameter int PRICE_BASE = 50,
  parameter int PRICE_STEP = 25,
  localparam int ITEM_W = $clog2(NUM_ITEMS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                btn_home,
  input  logic                btn_step,
  input  logic                btn_pick,
  input  logic                btn_coin,
  output logic [2:0]          screen_o,
  output logic [ITEM_W-1:0]   item_o,
  output logic [CREDIT_W-1:0] credit_o,
  output logic                vend_o
);
  screen_e             screen;
  logic                go_home, enter_vend, vend_q;
  logic                pick_ev, coin_ev, credit_ok;
  logic [ITEM_W-1:0]   item;
  logic [CREDIT_W-1:0] credit;
  logic [CREDIT_W:0]   price;

  // price of the chosen item; one bit wider so it cannot truncate
  assign price     = (CREDIT_W+1)'(price_of(int'(item), PRICE_BASE, PRICE_STEP));
  assign credit_ok = {1'b0, credit} >= price;

  // buttons count only on their own screen and never alongside navigation
  assign pick_ev = btn_pick && !btn_home && !btn_step && screen == SCR_SELECT;
  assign coin_ev = btn_coin && !btn_home && !btn_step && screen == SCR_DEPOSIT;

  vmc_screen_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .home_ev(btn_home), .step_ev(btn_step),
    .credit_ok(credit_ok), .screen(screen), .go_home(go_home),
    .enter_vend(enter_vend), .vend_q(vend_q)
  );

  vmc_item_sel #(.NUM_ITEMS(NUM_ITEMS)) u_item (
    .clk(clk), .rst_n(rst_n), .clear(go_home), .adv(pick_ev), .idx(item)
  );

  vmc_credit #(.CREDIT_W(CREDIT_W), .COIN_STEP(COIN_STEP)) u_credit (
    .clk(clk), .rst_n(rst_n), .clear(go_home), .add(coin_ev), .credit(credit)
  );

  assign screen_o = screen;
  assign item_o   = item;
  assign credit_o = credit;
  assign vend_o   = vend_q;
endmodule

// File: rtl/vmc_checker.sv
module vmc_checker #(
  parameter int CREDIT_W = 8,
  parameter int ITEM_W   = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                btn_home,
  input logic                btn_step,
  input logic                btn_pick,
  input logic                btn_coin,
  input logic [2:0]          screen_o,
  input logic [ITEM_W-1:0]   item_o,
  input logic [CREDIT_W-1:0] credit_o,
  input logic                vend_o,
  input logic [CREDIT_W:0]   price,
  input logic                enter_vend
);
  logic ends_session;
  assign ends_session = btn_home || (btn_step && screen_o == 3'd4);

  AST_HOME_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    btn_home |=> (screen_o == 3'd0 && credit_o == '0 && item_o == '0)); // R2
  AST_STEP_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (!btn_home && btn_step && screen_o == 3'd0) |=> screen_o == 3'd1); // R3
  AST_SHORT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (!btn_home && btn_step && screen_o == 3'd2 && {1'b0, credit_o} < price)
      |=> screen_o == 3'd3); // R6
  AST_SHORT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!btn_home && btn_step && screen_o == 3'd3)
      |=> (screen_o == 3'd2 && $stable(credit_o))); // R7
  AST_VEND_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    vend_o |=> !vend_o); // R8
  AST_VEND_ON_SCREEN: assert property (@(posedge clk) disable iff (!rst_n)
    enter_vend |=> (vend_o && screen_o == 3'd4)); // R8
  AST_VEND_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!btn_home && btn_step && screen_o == 3'd4)
      |=> (screen_o == 3'd0 && credit_o == '0)); // R9
  AST_CREDIT_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !ends_session |=> credit_o >= $past(credit_o)); // R5
  AST_ITEM_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ends_session && (screen_o != 3'd1 || btn_step || !btn_pick))
      |=> $stable(item_o)); // R10
  AST_COIN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ends_session && (screen_o != 3'd2 || btn_step || !btn_coin))
      |=> $stable(credit_o)); // R10
endmodule

bind vend_menu_ctrl vmc_checker #(.CREDIT_W(CREDIT_W), .ITEM_W(ITEM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .btn_home(btn_home), .btn_step(btn_step),
  .btn_pick(btn_pick), .btn_coin(btn_coin), .screen_o(screen_o),
  .item_o(item_o), .credit_o(credit_o), .vend_o(vend_o), .price(price),
  .enter_vend(enter_vend)
);

// File: tb/sim_vend_menu_ctrl.sv
`timescale 1ns/1ps
module sim_vend_menu_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic b_home = 1'b0, b_step = 1'b0, b_pick = 1'b0, b_coin = 1'b0;
  logic [2:0] screen;
  logic [1:0] item;
  logic [7:0] credit;
  logic       vend;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vend_menu_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .btn_home(b_home), .btn_step(b_step),
    .btn_pick(b_pick), .btn_coin(b_coin), .screen_o(screen),
    .item_o(item), .credit_o(credit), .vend_o(vend)
  );

  function automatic int price_for(int idx);
    int tbl [4] = '{50, 75, 100, 125};
    return tbl[idx];
  endfunction

  task automatic chk(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // h,s,p,c : buttons held high for one cycle, sampled at the next negedge
  task automatic press(bit h, bit s, bit p, bit c);
    @(negedge clk);
    b_home = h; b_step = s; b_pick = p; b_coin = c;
    @(negedge clk);
    b_home = 0; b_step = 0; b_pick = 0; b_coin = 0;
  endtask
  task automatic step();  press(0, 1, 0, 0); endtask
  task automatic pick();  press(0, 0, 1, 0); endtask
  task automatic coin();  press(0, 0, 0, 1); endtask
  task automatic home();  press(1, 0, 0, 0); endtask

  task automatic t_reset();
    chk("R1 screen", screen, 0);
    chk("R1 item", item, 0);
    chk("R1 credit", credit, 0);
    chk("R1 vend", vend, 0);
  endtask

  task automatic t_nav_and_wrap();
    step(); chk("R3 home->select", screen, 1);
    for (int i = 1; i <= 5; i++) begin
      pick(); chk("R4 item", item, i % 4);
    end
    step(); chk("R3 select->deposit", screen, 2);
    home(); chk("R2 screen", screen, 0); chk("R2 item", item, 0);
  endtask

  task automatic t_short_then_vend();
    step(); pick(); step();                    // item 1, deposit
    coin(); coin(); chk("R5 credit", credit, 50);
    step(); chk("R6 short screen", screen, 3);
    coin(); pick(); chk("R10 coin on short", credit, 50);
    chk("R10 pick on short", item, 1);
    step(); chk("R7 back to deposit", screen, 2); chk("R7 credit kept", credit, 50);
    coin(); chk("R5 credit", credit, 75);
    step(); chk("R8 vend screen exact", screen, 4); chk("R8 vend high", vend, 1);
    @(negedge clk); chk("R8 vend one cycle", vend, 0);
    chk("R8 credit held", credit, 75);
    coin(); pick(); chk("R10 coin on vend", credit, 75); chk("R10 pick on vend", item, 1);
    step(); chk("R9 home", screen, 0); chk("R9 credit", credit, 0); chk("R9 item", item, 0);
  endtask

  task automatic t_dear_item_over();
    step(); pick(); pick(); pick(); step();      // item 3
    for (int i = 0; i < 4; i++) coin();
    chk("R5 credit", credit, 100);
    step(); chk("R6 below 125", screen, 3);
    step(); coin(); coin();
    chk("R5 credit", credit, 150);
    chk("R6 price table", price_for(item) <= credit, 1);
    step(); chk("R8 vend over", screen, 4); chk("R8 vend", vend, 1);
    home(); chk("R2 from vend", screen, 0); chk("R2 credit", credit, 0);
  endtask

  task automatic t_ignore_and_priority();
    pick(); coin(); chk("R10 pick on home", item, 0); chk("R10 coin on home", credit, 0);
    step(); coin(); chk("R10 coin on select", credit, 0);
    press(0, 1, 1, 0); chk("R3 step wins", screen, 2); chk("R10 pick with step", item, 0);
    coin(); pick(); chk("R10 pick on deposit", item, 0);
    press(0, 1, 0, 1); chk("R10 coin with step", credit, 25);
    chk("R6 short", screen, 3);
    step(); coin();
    press(1, 1, 1, 1); chk("R2 home priority", screen, 0);
    chk("R2 credit", credit, 0); chk("R2 item", item, 0);
  endtask

  task automatic t_saturate();
    step(); step();
    for (int i = 1; i <= 10; i++) coin();
    chk("R5 credit 250", credit, 250);
    coin(); chk("R5 saturate", credit, 255);
    coin(); chk("R5 hold max", credit, 255);
    step(); chk("R8 vend", screen, 4);
    home();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_nav_and_wrap();
    t_short_then_vend();
    t_dear_item_over();
    t_ignore_and_priority();
    t_saturate();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule